// File: doc/BRIEF.md
# Glitch-Free Reprogrammable Clock Divider

This block derives one output clock from an input clock by a whole-number ratio from 1 to 256. The ratio comes from an 8-bit code and a load strobe. A host may change the ratio while the output is running. The block then lets the pulse in progress finish, parks the output low, installs the new ratio and restarts it. No pulse shorter than half the shorter of the two periods ever appears on the output.

Even ratios come from a single rising-edge counter. Odd ratios above one add a copy of the counter's output that is retimed on the falling edge, so the duty cycle stays at 50%. Divide-by-1 does not use the counter; it passes the input clock through an enable that is retimed on the falling edge. A sync input forces the output low and resets the count. Every restart, whether after reset, after sync or after a ratio change, follows a fixed launch sequence whose length does not depend on the ratio. Dividers that are released from sync on the same input edge therefore produce their first rising edges together.

All pins are plain control and status signals. There is no streaming interface and no back-pressure.

Top module: `glitchless_clkdiv`

## Requirements
- R1: While reset is low the output is low and busy is high; the code defaults to divide-by-1, and the first output rising edge comes on the START_CYC-th input rising edge after reset is released.
- R2: Code value c selects divide-by-(c+1), so 0 gives 1 and 255 gives 256; in steady state the output period is c+1 input periods.
- R3: For an even ratio N the output is high for exactly N/2 input periods, and every output rising edge coincides with an input rising edge.
- R4: For an odd ratio N above 1 the output is high for N/2 input periods: it rises on an input rising edge and falls on an input falling edge.
- R5: At divide-by-1 the output follows the input clock, high for half an input period in every period.
- R6: A load strobe sampled while busy is low is accepted, and busy is high from the following edge. The pulse in progress completes, the output stays low, and then it restarts at the new ratio. No high pulse in the transition is shorter than half the shorter of the old and new periods.
- R7: Busy falls on the same input rising edge that produces the first output rising edge at the new ratio.
- R8: A load strobe sampled while busy is high is ignored, and the ratio that was accepted first stays in force.
- R9: While sync is sampled high, the output is low from the next input rising edge. After sync is first sampled low, the first output rising edge comes START_CYC+1 input periods later, for every ratio.
- R10: A load strobe accepted while sync holds the output low takes effect at the restart that follows the release of sync.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_code_i | input | 8 | Ratio code, divide by value plus one |
| load_i | input | 1 | Strobe that requests the code on div_code_i |
| sync_i | input | 1 | Holds the output low and realigns its phase on release |
| clk_o | output | 1 | Divided output clock |
| busy_o | output | 1 | High while a ratio change or restart is in progress |

## Verification
The ratio is stepped through divide-by-2, 3, 8, 7, 256, 1 and 5, and every step is a live change from the previous ratio. This separates the even counter path, the odd path with its falling-edge tail, the top of the code range and the pass-through path, and it tests each transition for short pulses and for the busy edge lining up with the first output edge. A double strobe shows that a second request made while busy has no effect. Sync is tried at divide-by-4 and divide-by-1, and again with a load made during the hold. Since the launch delay measured after release must be the same each time, a delay that depended on the ratio would show up.

// File: rtl/gdiv_pkg.sv
package gdiv_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_DRAIN,
    ST_PARK,
    ST_START,
    ST_HOLD
  } gdiv_state_e;

  typedef enum logic [1:0] {
    CNT_CLEAR,
    CNT_COUNT,
    CNT_LAUNCH
  } gdiv_cmd_e;

endpackage

// File: rtl/gdiv_ctrl.sv
module gdiv_ctrl
  import gdiv_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int START_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              load_i,
  input  logic              sync_i,
  input  logic              low_next_i,
  output gdiv_cmd_e         cmd_o,
  output logic              gate_en_o,
  output logic [CODE_W-1:0] div_o,
  output logic              byp_o,
  output logic              odd_o,
  output logic              busy_o,
  output gdiv_state_e       state_o
);

  localparam int SC_W = (START_CYC > 2) ? $clog2(START_CYC) : 1;
  localparam logic [SC_W-1:0] SC_LAST = SC_W'(START_CYC - 1);
  localparam logic [SC_W-1:0] SC_ONE  = SC_W'(1);

  gdiv_state_e       state_q, state_d;
  logic [SC_W-1:0]   stcnt_q, stcnt_d;
  logic [CODE_W-1:0] div_q, div_d;
  logic [CODE_W-1:0] pend_q, pend_d;
  logic              pend_v_q, pend_v_d;
  logic              gate_q, gate_d;
  logic              bypass;
  logic              load_acc;

  assign bypass   = (div_q == '0);
  assign busy_o   = pend_v_q | (state_q == ST_DRAIN) | (state_q == ST_PARK) |
                    (state_q == ST_START);
  assign load_acc = load_i & ~busy_o;

  always_comb begin
    state_d  = state_q;
    stcnt_d  = stcnt_q;
    div_d    = div_q;
    pend_d   = pend_q;
    pend_v_d = pend_v_q;
    gate_d   = gate_q;
    cmd_o    = CNT_CLEAR;
    if (load_acc) begin
      pend_d   = code_i;
      pend_v_d = 1'b1;
    end
    unique case (state_q)
      ST_RUN: begin
        if (sync_i) begin
          state_d = ST_HOLD;
          gate_d  = 1'b0;
        end else begin
          cmd_o = bypass ? CNT_CLEAR : CNT_COUNT;
          if (load_acc) state_d = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (sync_i) begin
          state_d = ST_HOLD;
          gate_d  = 1'b0;
        end else if (bypass) begin
          gate_d  = 1'b0;
          state_d = ST_PARK;
        end else if (low_next_i) begin
          state_d = ST_PARK;
        end else begin
          cmd_o = CNT_COUNT;
        end
      end
      ST_PARK: begin
        if (pend_v_q) begin
          div_d    = pend_q;
          pend_v_d = 1'b0;
        end
        state_d = ST_START;
        stcnt_d = SC_LAST;
      end
      ST_START: begin
        if (sync_i) begin
          state_d = ST_HOLD;
          gate_d  = 1'b0;
        end else if (stcnt_q == '0) begin
          state_d = ST_RUN;
          if (!bypass) cmd_o = CNT_LAUNCH;
        end else begin
          stcnt_d = stcnt_q - SC_ONE;
          if ((stcnt_q == SC_ONE) && bypass) gate_d = 1'b1;
        end
      end
      ST_HOLD: begin
        gate_d = 1'b0;
        if (!sync_i) state_d = ST_PARK;
      end
      default: state_d = ST_PARK;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_START;
      stcnt_q  <= SC_LAST;
      div_q    <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      gate_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      stcnt_q  <= stcnt_d;
      div_q    <= div_d;
      pend_q   <= pend_d;
      pend_v_q <= pend_v_d;
      gate_q   <= gate_d;
    end
  end

  assign gate_en_o = gate_q;
  assign div_o     = div_q;
  assign byp_o     = bypass;
  assign odd_o     = ~div_q[0];
  assign state_o   = state_q;

  // R8: a strobe during a drain leaves the captured request untouched
  a_r8_busy_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && state_q == ST_DRAIN) |=> (pend_q == $past(pend_q)));

  // R9: sync removes the pass-through enable on the next edge
  a_r9_gate_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> !gate_q);

endmodule

// File: rtl/gdiv_count.sv
module gdiv_count
  import gdiv_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  gdiv_cmd_e         cmd_i,
  input  logic [CODE_W-1:0] lim_i,
  input  logic              odd_i,
  output logic              low_next_o,
  output logic              rise_o,
  output logic              wave_o
);

  logic [CODE_W-1:0] cnt_q, cnt_nxt, half;
  logic [CODE_W:0]   n_full;
  logic              rise_q, tail_q;

  assign n_full     = {1'b0, lim_i} + (CODE_W+1)'(1);
  assign half       = n_full[CODE_W:1];
  assign cnt_nxt    = (cnt_q >= lim_i) ? '0 : cnt_q + CODE_W'(1);
  assign low_next_o = (cnt_nxt >= half);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rise_q <= 1'b0;
    end else begin
      unique case (cmd_i)
        CNT_COUNT: begin
          cnt_q  <= cnt_nxt;
          rise_q <= (cnt_nxt < half);
        end
        CNT_LAUNCH: begin
          cnt_q  <= '0;
          rise_q <= 1'b1;
        end
        default: begin
          cnt_q  <= '0;
          rise_q <= 1'b0;
        end
      endcase
    end
  end

  // half-cycle extension for odd ratios
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tail_q <= 1'b0;
    else         tail_q <= rise_q & odd_i;
  end

  assign rise_o = rise_q;
  assign wave_o = rise_q | tail_q;

  // R2: the count never leaves the range selected by the code
  a_r2_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim_i);

  // R3: even ratios never carry the falling-edge extension
  a_r3_even_no_tail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !odd_i |-> !tail_q);

endmodule

// File: rtl/gdiv_gate.sv
module gdiv_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic en_o,
  output logic gclk_o
);

  logic en_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_i;
  end

  assign en_o   = en_q;
  assign gclk_o = clk_i & en_q;

endmodule

// File: rtl/glitchless_clkdiv.sv
module glitchless_clkdiv
  import gdiv_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int START_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] div_code_i,
  input  logic              load_i,
  input  logic              sync_i,
  output logic              clk_o,
  output logic              busy_o
);

  gdiv_cmd_e         cmd;
  gdiv_state_e       state;
  logic [CODE_W-1:0] div;
  logic              byp, odd, low_next, gate_en, gate_q, gclk, rise, wave;

  gdiv_ctrl #(.CODE_W(CODE_W), .START_CYC(START_CYC)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .code_i     (div_code_i),
    .load_i     (load_i),
    .sync_i     (sync_i),
    .low_next_i (low_next),
    .cmd_o      (cmd),
    .gate_en_o  (gate_en),
    .div_o      (div),
    .byp_o      (byp),
    .odd_o      (odd),
    .busy_o     (busy_o),
    .state_o    (state)
  );

  gdiv_count #(.CODE_W(CODE_W)) u_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd),
    .lim_i      (div),
    .odd_i      (odd),
    .low_next_o (low_next),
    .rise_o     (rise),
    .wave_o     (wave)
  );

  gdiv_gate u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (gate_en),
    .en_o   (gate_q),
    .gclk_o (gclk)
  );

  // select only changes in the park state, where both paths are low
  assign clk_o = byp ? gclk : wave;

  // R6: both output paths are quiet while the new ratio is installed
  a_r6_park_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_PARK) |-> (!wave && !gate_q));

  // R7: busy drops exactly when the restarted output goes high
  a_r7_busy_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (byp ? gate_q : rise));

  // R9: the counter path is low one edge after sync is seen
  a_r9_hold_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> !wave);

endmodule

// File: tb/test_glitchless_clkdiv.sv
module test_glitchless_clkdiv;

  localparam int CLK_T = 10;
  localparam int LAT   = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic       sync = 1'b0;
  logic [7:0] code = '0;
  logic       clk_o, busy;

  glitchless_clkdiv #(.CODE_W(8), .START_CYC(LAT)) i_glitchless_clkdiv (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .div_code_i (code),
    .load_i     (load),
    .sync_i     (sync),
    .clk_o      (clk_o),
    .busy_o     (busy)
  );

  always #(CLK_T/2) clk = ~clk;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  int  exp_q[$];
  bit  armed = 1'b0;
  int  cur_n = 1;
  time last_rise = 0, last_fall = 0, last_period = 0, t_bfall = 0;
  time min_hi = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string hi_tag(input int n);
    if (n == 1)      return "R5";
    else if (n % 2)  return "R4";
    else             return "R3";
  endfunction

  // monitor: compares each completed output period against the queue
  always @(posedge clk_o) begin
    int n;
    if (armed && exp_q.size() > 0) begin
      n = exp_q.pop_front();
      check(($time - last_rise) == time'(n*CLK_T), "R2", "period",
            longint'($time - last_rise), n*CLK_T);
      check((last_fall - last_rise) == time'(n*CLK_T/2), hi_tag(n), "high time",
            longint'(last_fall - last_rise), n*CLK_T/2);
    end
    last_period = $time - last_rise;
    last_rise   = $time;
  end

  always @(negedge clk_o) begin
    last_fall = $time;
    if (($time - last_rise) < min_hi) min_hi = $time - last_rise;
  end

  always @(negedge busy) t_bfall = $time;

  // driver side of the scoreboard
  task automatic run_periods(input int n, input int cnt);
    @(negedge clk);
    for (int i = 0; i < cnt; i++) exp_q.push_back(n);
    armed = 1'b1;
    while (exp_q.size() > 0) @(negedge clk);
    armed = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic load_ratio(input int c, input int cnt, input int second);
    int newn = c + 1;
    int lo   = (newn < cur_n) ? newn : cur_n;
    min_hi = 64'hFFFF_FFFF;
    @(negedge clk);
    code = 8'(c);
    load = 1'b1;
    @(negedge clk);
    if (second >= 0) code = 8'(second);
    else             load = 1'b0;
    check(busy == 1'b1, "R6", "busy after accepted load", busy, 1);
    if (second >= 0) begin
      @(negedge clk);
      load = 1'b0;
    end
    wait_idle();
    check(t_bfall == last_rise, "R7", "busy fall vs first new rise",
          longint'(t_bfall), longint'(last_rise));
    run_periods(newn, cnt);
    check(min_hi >= time'(lo*CLK_T/2), "R6", "shortest high pulse in change",
          longint'(min_hi), lo*CLK_T/2);
    if (second >= 0)
      check(last_period == time'(newn*CLK_T), "R8", "period after ignored strobe",
            longint'(last_period), newn*CLK_T);
    cur_n = newn;
  endtask

  task automatic sync_cycle(input int c, input int cnt);
    time t0;
    @(negedge clk);
    sync = 1'b1;
    @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      check(clk_o == 1'b0, "R9", "output low during sync (clock low)", clk_o, 0);
      @(posedge clk);
      #1;
      check(clk_o == 1'b0, "R9", "output low during sync (clock high)", clk_o, 0);
      @(negedge clk);
    end
    if (c >= 0) begin
      code = 8'(c);
      load = 1'b1;
      @(negedge clk);
      load = 1'b0;
      check(busy == 1'b1, "R10", "busy after load during hold", busy, 1);
      cur_n = c + 1;
    end
    sync = 1'b0;
    t0 = $time;
    @(posedge clk_o);
    check($time == t0 + time'(CLK_T/2 + (LAT+1)*CLK_T), "R9", "first rise after release",
          longint'($time - t0), CLK_T/2 + (LAT+1)*CLK_T);
    run_periods(cur_n, cnt);
    check(!busy, "R7", "busy low after restart", busy, 0);
    if (c >= 0)
      check(last_period == time'(cur_n*CLK_T), "R10", "ratio loaded during hold",
            longint'(last_period), cur_n*CLK_T);
  endtask

  initial begin
    time t0;
    // R1: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(clk_o == 1'b0, "R1", "output in reset", clk_o, 0);
      check(busy == 1'b1, "R1", "busy in reset", busy, 1);
      @(posedge clk);
      #1;
      check(clk_o == 1'b0, "R1", "output in reset (clock high)", clk_o, 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    t0 = $time;
    @(posedge clk_o);
    check($time == t0 + time'(CLK_T/2 + (LAT-1)*CLK_T), "R1", "first rise after reset",
          longint'($time - t0), CLK_T/2 + (LAT-1)*CLK_T);
    run_periods(1, 4);
    cur_n = 1;

    load_ratio(1,   3, -1);   // divide by 2
    load_ratio(2,   3, -1);   // divide by 3
    load_ratio(7,   2, -1);   // divide by 8
    load_ratio(6,   2, -1);   // divide by 7
    load_ratio(255, 2, -1);   // divide by 256
    load_ratio(0,   4, -1);   // divide by 1
    load_ratio(4,   3, -1);   // divide by 5
    load_ratio(3,   3,  9);   // divide by 4, second strobe ignored (R8)

    sync_cycle(-1, 3);        // sync at divide by 4
    load_ratio(0,   3, -1);
    sync_cycle(-1, 3);        // sync at divide by 1
    sync_cycle(6,  2);        // load divide by 7 during hold

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_T * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule